// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column address for every beat of a synchronous DRAM burst. A configuration word is written into it once. That word selects four things: the burst length, the ordering of the beats, the read latency, and whether writes run as full bursts or as single beats. After that, each burst request carries a starting column and a read/write flag. From the cycle after the request, the block presents one column per cycle. Alongside the column it raises a beat-valid flag, and it raises a last-beat flag on the final beat.

Fixed-length bursts stay inside the aligned block of their length. They step either linearly with wrap-around or in XOR order. A full-page burst walks the whole column space and wraps at its end. It only ends when a stop request arrives. A stop request also cuts a fixed-length burst short. The decoded read latency is reported on its own output so that neighbouring logic can time the data.

Top module: `burstColSeq`

## Requirements
- R1: After reset, beatValid and lastBeat are low, casLat reads 2, and the configuration is a one-beat sequential burst with burst writes.
- R2: A configuration word is taken when modeWe is high at a clock edge. The fields are:
  - bits [2:0]: length (000=1, 001=2, 010=4, 011=8, 111=full page)
  - bit 3: order (0 linear, 1 XOR)
  - bits [6:4]: read latency (010=2, 011=3)
  - bit 9: write mode (0 burst writes, 1 single-beat writes)
- R3: A configuration word with a reserved length code (100, 101, 110) or a latency code other than 010/011 is ignored entirely. The previous setting stays in force.
- R4: When burstStart is high at an edge, the first beat appears in the next cycle with colOut equal to burstCol and beatValid high. Each later beat follows one cycle after the one before it.
- R5: In linear order with length L of 2, 4 or 8, beat i has low log2(L) column bits equal to (start+i) mod L. The upper bits keep their starting value.
- R6: In XOR order with length L, beat i has low log2(L) bits equal to the starting low bits XOR i. The upper bits keep their starting value.
- R7: A full-page burst outputs start+i modulo 256 and ignores the order bit. It runs until stopped and never raises lastBeat on its own.
- R8: lastBeat is high only on the final beat of a burst. beatValid is low the cycle after it, unless a new burst starts.
- R9: If burstStop is high at an edge while a non-final beat is shown, the next beat is the final one and has lastBeat high. A stop while idle has no effect.
- R10: With single-beat writes selected, a write burst has exactly one beat, while a read burst keeps the full length. With burst writes selected, writes use the full length.
- R11: A burstStart during a burst restarts it from the new column. burstStart takes priority over burstStop at the same edge.
- R12: casLat reports the latency of the last accepted configuration word (2 or 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWe | input | 1 | Configuration write strobe |
| modeWord | input | 12 | Configuration word |
| burstStart | input | 1 | Burst request |
| burstIsWrite | input | 1 | Request is a write |
| burstCol | input | 8 | Starting column |
| burstStop | input | 1 | Stop request for the running burst |
| colOut | output | 8 | Column of the current beat |
| beatValid | output | 1 | A beat is presented this cycle |
| lastBeat | output | 1 | Current beat is the final one |
| casLat | output | 2 | Decoded read latency |

## Verification
The assertions check the burst framing on every cycle:
- the first beat follows a request and carries the requested column;
- lastBeat never appears without a valid beat, and the burst ends after it;
- a stop turns the next beat into the final one;
- the stop is ignored while idle;
- the latency output stays legal and only changes on a configuration write.

The column order within a burst, the burst length and its wrap points, rejection of reserved words, and the single-beat write rule all depend on the configuration word. Only the bench's scenarios demonstrate those, by comparing every beat against columns computed from the requirements.

// File: rtl/burstSeqPkg.sv
package burstSeqPkg;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;

  typedef struct packed {
    logic [2:0] lenCode;
    logic       interleave;
    logic [1:0] casLat;
    logic       singleWrite;
  } modeCfg_t;

  localparam logic [2:0] LEN_PAGE = 3'b111;

  function automatic logic lenCodeOk(input logic [2:0] code);
    return (code == 3'd0) || (code == 3'd1) || (code == 3'd2) ||
           (code == 3'd3) || (code == LEN_PAGE);
  endfunction

endpackage

// File: rtl/burstModeReg.sv
module burstModeReg
  import burstSeqPkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeWord,
  output modeCfg_t          cfg
);
  localparam int TYPE_BIT = 3;
  localparam int CL_LSB   = 4;
  localparam int WM_BIT   = 9;

  logic [2:0] lenField;
  logic [2:0] clField;
  logic       wordOk;

  always_comb begin
    lenField = modeWord[2:0];
    clField  = modeWord[CL_LSB +: 3];
    wordOk   = lenCodeOk(lenField) && ((clField == 3'd2) || (clField == 3'd3));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '{lenCode: 3'd0, interleave: 1'b0, casLat: 2'd2, singleWrite: 1'b0};
    end else if (modeWe && wordOk) begin
      cfg.lenCode     <= lenField;
      cfg.interleave  <= modeWord[TYPE_BIT] && (lenField != LEN_PAGE);
      cfg.casLat      <= clField[1:0];
      cfg.singleWrite <= modeWord[WM_BIT];
    end
  end
endmodule

// File: rtl/burstCtrl.sv
module burstCtrl
  import burstSeqPkg::*;
#(
  parameter int MAX_FIXED = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  modeCfg_t   cfg,
  input  logic       burstStart,
  input  logic       burstIsWrite,
  input  logic       burstStop,
  output seqStrobe_t strobe,
  output logic       beatValid,
  output logic       lastBeat
);
  localparam int CNT_W = $clog2(MAX_FIXED) + 1;

  logic             activeQ;
  logic             lastQ;
  logic             pageQ;
  logic [CNT_W-1:0] leftQ;

  logic             oneBeat;
  logic             startPage;
  logic [CNT_W-1:0] startLeft;

  always_comb begin
    oneBeat   = burstIsWrite && cfg.singleWrite;
    startPage = (cfg.lenCode == LEN_PAGE) && !oneBeat;
    startLeft = '0;
    if (!oneBeat) begin
      case (cfg.lenCode)
        3'd1:    startLeft = CNT_W'(1);
        3'd2:    startLeft = CNT_W'(3);
        3'd3:    startLeft = CNT_W'(7);
        default: startLeft = '0;
      endcase
    end
    strobe.load = burstStart;
    strobe.step = !burstStart && activeQ && !lastQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      lastQ   <= 1'b0;
      pageQ   <= 1'b0;
      leftQ   <= '0;
    end else if (burstStart) begin
      activeQ <= 1'b1;
      pageQ   <= startPage;
      leftQ   <= startLeft;
      lastQ   <= !startPage && (startLeft == '0);
    end else if (activeQ) begin
      if (lastQ) begin
        activeQ <= 1'b0;
        lastQ   <= 1'b0;
      end else if (burstStop) begin
        lastQ <= 1'b1;
      end else if (!pageQ) begin
        leftQ <= leftQ - CNT_W'(1);
        lastQ <= (leftQ == CNT_W'(1));
      end
    end
  end

  assign beatValid = activeQ;
  assign lastBeat  = lastQ;
endmodule

// File: rtl/burstAddrPath.sv
module burstAddrPath
  import burstSeqPkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  modeCfg_t         cfg,
  input  seqStrobe_t       strobe,
  input  logic [COL_W-1:0] startCol,
  output logic [COL_W-1:0] colOut
);
  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] idxQ;
  logic [COL_W-1:0] maskQ;
  logic             ilvQ;
  logic [COL_W-1:0] maskNext;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] ilvCol;

  always_comb begin
    case (cfg.lenCode)
      3'd0:    maskNext = '0;
      3'd1:    maskNext = COL_W'(1);
      3'd2:    maskNext = COL_W'(3);
      3'd3:    maskNext = COL_W'(7);
      default: maskNext = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      idxQ  <= '0;
      maskQ <= '0;
      ilvQ  <= 1'b0;
    end else if (strobe.load) begin
      baseQ <= startCol;
      idxQ  <= '0;
      maskQ <= maskNext;
      ilvQ  <= cfg.interleave;
    end else if (strobe.step) begin
      idxQ <= idxQ + COL_W'(1);
    end
  end

  always_comb begin
    seqCol = (baseQ & ~maskQ) | ((baseQ + idxQ) & maskQ);
    ilvCol = baseQ ^ (idxQ & maskQ);
    colOut = ilvQ ? ilvCol : seqCol;
  end
endmodule

// File: rtl/burstColSeq.sv
module burstColSeq
  import burstSeqPkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              burstStart,
  input  logic              burstIsWrite,
  input  logic [COL_W-1:0]  burstCol,
  input  logic              burstStop,
  output logic [COL_W-1:0]  colOut,
  output logic              beatValid,
  output logic              lastBeat,
  output logic [1:0]        casLat
);
  modeCfg_t   cfg;
  seqStrobe_t strobe;

  burstModeReg #(.MODE_W(MODE_W)) uMode (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeWord(modeWord), .cfg(cfg)
  );

  burstCtrl #(.MAX_FIXED(8)) uCtrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .burstStart(burstStart),
    .burstIsWrite(burstIsWrite), .burstStop(burstStop), .strobe(strobe),
    .beatValid(beatValid), .lastBeat(lastBeat)
  );

  burstAddrPath #(.COL_W(COL_W)) uPath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe),
    .startCol(burstCol), .colOut(colOut)
  );

  assign casLat = cfg.casLat;
endmodule

// File: rtl/burstSeqChk.sv
module burstSeqChk #(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              modeWe,
  input logic [MODE_W-1:0] modeWord,
  input logic              burstStart,
  input logic              burstIsWrite,
  input logic [COL_W-1:0]  burstCol,
  input logic              burstStop,
  input logic [COL_W-1:0]  colOut,
  input logic              beatValid,
  input logic              lastBeat,
  input logic [1:0]        casLat
);
  // R4
  first_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |=> beatValid && (colOut == $past(burstCol)));

  // R8
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid);

  // R8
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !burstStart) |=> !beatValid);

  // R9
  stop_makes_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && !lastBeat && burstStop && !burstStart) |=> (beatValid && lastBeat));

  // R9
  idle_stays_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!beatValid && !burstStart) |=> !beatValid);

  // R12
  latency_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (casLat == 2'd2) || (casLat == 2'd3));

  // R3
  latency_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeWe |=> $stable(casLat));
endmodule

bind burstColSeq burstSeqChk #(.COL_W(COL_W), .MODE_W(MODE_W)) uChk (.*);

// File: tb/sim_burstColSeq.sv
module sim_burstColSeq;
  logic        clk = 1'b0;
  logic        rstN;
  logic        modeWe;
  logic [11:0] modeWord;
  logic        burstStart;
  logic        burstIsWrite;
  logic [7:0]  burstCol;
  logic        burstStop;
  logic [7:0]  colOut;
  logic        beatValid;
  logic        lastBeat;
  logic [1:0]  casLat;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  burstColSeq u0 (.*);

  // mode(12) write(1) col(8) beats(4)
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {12'h022, 1'b0, 8'h16, 4'd4},
    {12'h033, 1'b1, 8'h2D, 4'd8},
    {12'h02B, 1'b0, 8'h2D, 4'd8},
    {12'h03A, 1'b0, 8'h0E, 4'd4},
    {12'h021, 1'b0, 8'h01, 4'd2},
    {12'h029, 1'b0, 8'h01, 4'd2},
    {12'h020, 1'b0, 8'h55, 4'd1},
    {12'h223, 1'b1, 8'h40, 4'd1},
    {12'h22A, 1'b0, 8'h4F, 4'd4},
    {12'h023, 1'b1, 8'hA3, 4'd8}
  };
  localparam string TAG [NV] = '{"R5", "R5", "R6", "R6", "R5", "R6", "R8", "R10", "R10", "R10"};

  function automatic logic [7:0] expCol(input logic [11:0] m, input logic [7:0] s, input int i);
    logic [7:0] msk;
    logic [7:0] ib;
    ib = 8'(i);
    if (m[2:0] == 3'b111) return s + ib;
    msk = 8'((1 << m[2:0]) - 1);
    if (m[3]) return s ^ (ib & msk);
    return (s & ~msk) | ((s + ib) & msk);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic loadMode(input logic [11:0] m);
    @(negedge clk);
    modeWe = 1'b1; modeWord = m;
    @(negedge clk);
    modeWe = 1'b0;
  endtask

  task automatic startBurst(input logic wr, input logic [7:0] c);
    @(negedge clk);
    burstStart = 1'b1; burstIsWrite = wr; burstCol = c;
    @(negedge clk);
    burstStart = 1'b0;
  endtask

  // Called at the negedge where beat 0 is visible.
  task automatic checkBeats(input string req, input logic [11:0] m, input logic [7:0] s, input int beats);
    for (int i = 0; i < beats; i++) begin
      chk(req, "valid", 32'(beatValid), 32'd1);
      chk(req, "col", 32'(colOut), 32'(expCol(m, s, i)));
      chk(req, "last", 32'(lastBeat), 32'(i == beats - 1));
      @(negedge clk);
    end
    chk(req, "valid after end", 32'(beatValid), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; modeWe = 1'b0; modeWord = '0; burstStart = 1'b0;
    burstIsWrite = 1'b0; burstCol = '0; burstStop = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "valid", 32'(beatValid), 32'd0);
    chk("R1", "last", 32'(lastBeat), 32'd0);
    chk("R1", "casLat", 32'(casLat), 32'd2);
    startBurst(1'b1, 8'h3C);
    checkBeats("R1", 12'h020, 8'h3C, 1);

    // table walk: R2 decoding, R4 timing, R12 latency
    for (int v = 0; v < NV; v++) begin
      loadMode(VEC[v][24:13]);
      chk("R12", "casLat", 32'(casLat), 32'(VEC[v][18:17]));
      startBurst(VEC[v][12], VEC[v][11:4]);
      checkBeats(TAG[v], VEC[v][24:13], VEC[v][11:4], int'(VEC[v][3:0]));
    end

    // R3 rejected words keep 8-beat, latency 3 setting
    loadMode(12'h033);
    loadMode(12'h052);
    chk("R3", "casLat after bad latency", 32'(casLat), 32'd3);
    loadMode(12'h034);
    startBurst(1'b0, 8'h12);
    checkBeats("R3", 12'h033, 8'h12, 8);

    // R7 full page, order bit ignored, wraps, then stopped (R9)
    loadMode(12'h03F);
    startBurst(1'b0, 8'hFC);
    for (int i = 0; i < 10; i++) begin
      chk("R7", "valid", 32'(beatValid), 32'd1);
      chk("R7", "col", 32'(colOut), 32'(8'(8'hFC + i)));
      chk("R7", "no last", 32'(lastBeat), 32'd0);
      if (i < 9) @(negedge clk);
    end
    burstStop = 1'b1;
    @(negedge clk);
    burstStop = 1'b0;
    chk("R9", "page stop last", 32'(lastBeat), 32'd1);
    chk("R9", "page stop col", 32'(colOut), 32'h06);
    @(negedge clk);
    chk("R9", "page idle", 32'(beatValid), 32'd0);

    // R9 stop on fixed burst, then stop while idle
    loadMode(12'h023);
    startBurst(1'b0, 8'h20);
    @(negedge clk);
    @(negedge clk);
    burstStop = 1'b1;
    @(negedge clk);
    burstStop = 1'b0;
    chk("R9", "fixed stop last", 32'(lastBeat), 32'd1);
    chk("R9", "fixed stop col", 32'(colOut), 32'h23);
    @(negedge clk);
    chk("R9", "fixed idle", 32'(beatValid), 32'd0);
    burstStop = 1'b1;
    @(negedge clk);
    burstStop = 1'b0;
    chk("R9", "idle stop ignored", 32'(beatValid), 32'd0);

    // R11 restart wins over stop
    startBurst(1'b0, 8'h80);
    @(negedge clk);
    burstStart = 1'b1; burstStop = 1'b1; burstCol = 8'h95;
    @(negedge clk);
    burstStart = 1'b0; burstStop = 1'b0;
    checkBeats("R11", 12'h023, 8'h95, 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule